// File: doc/BRIEF.md
# Run-Length Bit Stream Expander

This block turns a stream of compressed code bytes into a serial bit stream, one bit per output handshake. Each code byte stands for one run of identical bits. The run may be followed by a single terminating bit of the opposite value. The expander is placed between a byte source, which already points at the compressed payload, and a serializer that drives the bits into a configurable device.

Every stream starts with a fixed 16-bit prefix, sent before any decoded bit. Bytes arrive on a valid/ready input with a last marker. The output bit that completes the last-marked byte carries an output last flag. Once that bit has been taken, the prefix is armed again for the next stream. One code byte is held at a time. The next byte is taken only after every bit of the current one has been accepted downstream.

Top module: `rle_bitstream_expander`

## Requirements
- R1: After reset, and after each stream ends, the output sends the 16 prefix bits 1111_1111_0010_0000, leftmost first. `in_ready_o` stays low until the last prefix bit has been accepted.
- R2: A code n with 1 <= n <= 226 produces n one-bits and then a single zero-bit.
- R3: Code 227 produces exactly 226 one-bits and no zero-bit after them.
- R4: A code n with 228 <= n <= 254 produces n-228 zero-bits and then a single one-bit. Code 228 therefore gives one one-bit.
- R5: Code 255 produces a single one-bit.
- R6: Code 0 produces no bits. It is taken in one cycle, and the input is ready again in the next cycle.
- R7: `in_ready_o` is never high while an output bit is pending. A new byte is taken only after the final bit of the previous code has been accepted.
- R8: `out_last_o` is high only on the final bit produced by a byte taken with `in_last_i` high. After that bit, or after a last-marked code 0, the prefix of R1 starts again.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_bit_o` and `out_last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Code byte valid |
| in_ready_o | output | 1 | Expander can take a code byte |
| in_data_i | input | 8 | Code byte |
| in_last_i | input | 1 | Code byte ends the stream |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_i | input | 1 | Downstream takes the bit |
| out_bit_o | output | 1 | Serial output bit |
| out_last_o | output | 1 | Final bit of the stream |

## Verification
A corrupted run counter shows up as a stream that is longer or shorter than expected. This is caught at the next code boundary, because `in_ready_o` rises early or late. A lost terminator flag drops the closing opposite bit, which changes the very next output bit. A stuck prefix flag shows up within 16 accepted bits, because the input never becomes ready or the prefix pattern breaks. The bench compares every accepted bit and its last flag against a model built from the code ranges, under both free-flowing and randomly stalled output.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned RUN_W  = CODE_W;

  typedef struct packed {
    logic [RUN_W-1:0] run_len;
    logic             run_bit;
    logic             has_tail;
  } rle_cmd_t;
endpackage

// File: rtl/rle_code_classify.sv
module rle_code_classify
  import rle_pkg::*;
#(
  parameter int unsigned MAX_ONES = 226
) (
  input  logic [CODE_W-1:0] code_i,
  output rle_cmd_t          cmd_o
);
  localparam logic [CODE_W-1:0] ONES_MAX  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] CAP_CODE  = CODE_W'(MAX_ONES + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);
  localparam logic [CODE_W-1:0] ONE_CODE  = '1;

  always_comb begin
    cmd_o = '0;
    if (code_i == '0) begin
      cmd_o.run_len  = '0;
      cmd_o.run_bit  = 1'b1;
      cmd_o.has_tail = 1'b0;
    end else if (code_i <= ONES_MAX) begin
      cmd_o.run_len  = code_i;
      cmd_o.run_bit  = 1'b1;
      cmd_o.has_tail = 1'b1;
    end else if (code_i == CAP_CODE) begin
      cmd_o.run_len  = ONES_MAX;
      cmd_o.run_bit  = 1'b1;
      cmd_o.has_tail = 1'b0;
    end else if (code_i == ONE_CODE) begin
      // tail only: inverted run bit gives a one
      cmd_o.run_len  = '0;
      cmd_o.run_bit  = 1'b0;
      cmd_o.has_tail = 1'b1;
    end else begin
      cmd_o.run_len  = code_i - ZERO_BASE;
      cmd_o.run_bit  = 1'b0;
      cmd_o.has_tail = 1'b1;
    end
  end
endmodule

// File: rtl/rle_prefix_gen.sv
module rle_prefix_gen #(
  parameter int unsigned                PREFIX_W = 16,
  parameter logic [PREFIX_W-1:0]        PREFIX   = 16'hFF20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic ready_i,
  output logic active_o,
  output logic bit_o
);
  localparam int unsigned IDX_W = $clog2(PREFIX_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PREFIX_W - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (restart_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q && ready_i) begin
      if (idx_q == IDX_LAST) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign bit_o    = PREFIX[PREFIX_W-1-int'(idx_q)];

  // restart only comes from the data phase
  p_restart_in_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !active_q);

  p_prefix_idle_idx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> idx_q == '0);
endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
  import rle_pkg::*;
#(
  parameter int unsigned MAX_ONES = 226
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  rle_cmd_t cmd_i,
  input  logic     last_i,
  input  logic     take_i,
  output logic     busy_o,
  output logic     bit_o,
  output logic     final_o,
  output logic     last_o
);
  logic [RUN_W-1:0] cnt_q;
  logic             run_bit_q;
  logic             tail_q;
  logic             last_q;
  logic             cnt_nz;

  assign cnt_nz = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      run_bit_q <= 1'b0;
      tail_q    <= 1'b0;
      last_q    <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= cmd_i.run_len;
      run_bit_q <= cmd_i.run_bit;
      tail_q    <= cmd_i.has_tail;
      last_q    <= last_i;
    end else if (take_i) begin
      if (cnt_nz) cnt_q  <= cnt_q - 1'b1;
      else        tail_q <= 1'b0;
    end
  end

  assign busy_o  = cnt_nz || tail_q;
  assign bit_o   = cnt_nz ? run_bit_q : ~run_bit_q;
  assign final_o = tail_q ? !cnt_nz : (cnt_q == RUN_W'(1));
  assign last_o  = last_q;

  p_load_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);

  p_run_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_W'(MAX_ONES));

  // last run bit taken with a pending tail: opposite bit follows
  p_tail_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && tail_q && cnt_q == RUN_W'(1)) |=> (busy_o && bit_o != $past(bit_o)));
endmodule

// File: rtl/rle_bitstream_expander.sv
module rle_bitstream_expander
  import rle_pkg::*;
#(
  parameter int unsigned         MAX_ONES = 226,
  parameter int unsigned         PREFIX_W = 16,
  parameter logic [PREFIX_W-1:0] PREFIX   = 16'hFF20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CODE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_bit_o,
  output logic              out_last_o
);
  rle_cmd_t cmd;
  logic     pfx_active, pfx_bit;
  logic     eng_busy, eng_bit, eng_final, eng_last;
  logic     accept, take, empty_code, restart;

  rle_code_classify #(.MAX_ONES(MAX_ONES)) i_classify (
    .code_i (in_data_i),
    .cmd_o  (cmd)
  );

  assign in_ready_o = !pfx_active && !eng_busy;
  assign accept     = in_valid_i && in_ready_o;
  assign take       = out_ready_i && !pfx_active && eng_busy;
  assign empty_code = (cmd.run_len == '0) && !cmd.has_tail;
  assign restart    = (accept && empty_code && in_last_i)
                   || (take && eng_final && eng_last);

  rle_prefix_gen #(.PREFIX_W(PREFIX_W), .PREFIX(PREFIX)) i_prefix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .ready_i   (out_ready_i),
    .active_o  (pfx_active),
    .bit_o     (pfx_bit)
  );

  rle_run_engine #(.MAX_ONES(MAX_ONES)) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .cmd_i   (cmd),
    .last_i  (in_last_i),
    .take_i  (take),
    .busy_o  (eng_busy),
    .bit_o   (eng_bit),
    .final_o (eng_final),
    .last_o  (eng_last)
  );

  assign out_valid_o = pfx_active || eng_busy;
  assign out_bit_o   = pfx_active ? pfx_bit : eng_bit;
  assign out_last_o  = !pfx_active && eng_busy && eng_final && eng_last;

  p_hold_under_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_bit_o) && $stable(out_last_o)));

  p_prefix_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> (out_valid_o && !in_ready_o));

  p_prefix_tail_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pfx_active) |-> $past(out_bit_o) == PREFIX[0]);

  p_zero_code_quick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_data_i == '0 && !in_last_i) |=> in_ready_o);
endmodule

// File: tb/test_rle_bitstream_expander.sv
module test_rle_bitstream_expander;
  localparam logic [15:0] PFX = 16'hFF20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_ready, out_bit, out_last;
  logic       bp_en = 1'b0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int stall_cnt = 0, stall_err = 0, ovl_err = 0;
  logic [1:0] exp_q[$];
  logic [1:0] got_q[$];

  always #2 clk = ~clk;

  rle_bitstream_expander i_rle_bitstream_expander (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_bit_o(out_bit), .out_last_o(out_last)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  // collector and port monitors
  logic pv = 1'b0, pr = 1'b0, pb = 1'b0, pl = 1'b0;
  always begin
    @(negedge clk);
    out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    #1;
    if (!rst_n) begin
      got_q.delete();
      pv = 1'b0;
    end else begin
      if (pv && !pr) begin
        stall_cnt++;
        if (!out_valid || out_bit != pb || out_last != pl) stall_err++;
      end
      if (in_ready && out_valid) ovl_err++;
      if (out_valid && out_ready) got_q.push_back({out_last, out_bit});
      pv = out_valid; pr = out_ready; pb = out_bit; pl = out_last;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_prefix();
    for (int i = 15; i >= 0; i--) exp_q.push_back({1'b0, PFX[i]});
  endtask

  task automatic add_code(input int c, input bit l);
    logic [1:0] tmp[$];
    if (c >= 1 && c <= 226) begin
      for (int i = 0; i < c; i++) tmp.push_back(2'b01);
      tmp.push_back(2'b00);
    end else if (c == 227) begin
      for (int i = 0; i < 226; i++) tmp.push_back(2'b01);
    end else if (c == 255) begin
      tmp.push_back(2'b01);
    end else if (c >= 228) begin
      for (int i = 0; i < c - 228; i++) tmp.push_back(2'b00);
      tmp.push_back(2'b01);
    end
    if (l && tmp.size() > 0) tmp[tmp.size()-1][1] = 1'b1;
    foreach (tmp[i]) exp_q.push_back(tmp[i]);
    if (l) add_prefix();
  endtask

  task automatic push_code(input int c, input bit l);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'(c); in_last = l;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send(input int c, input bit l);
    add_code(c, l);
    push_code(c, l);
  endtask

  task automatic drain();
    int k = 0;
    @(negedge clk); #1;
    while (!(in_ready && !out_valid) && k < 5000) begin
      @(negedge clk); #1; k++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    check(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
    foreach (exp_q[i]) if (bad < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) bad = i;
    if (bad >= 0 && bad < got_q.size())
      check(1'b0, req, "bit/last at index", int'(got_q[bad]), int'(exp_q[bad]));
    else
      check(bad < 0, req, "stream content", bad, -1);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; bp_en = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    add_prefix();
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check(out_valid == 1'b1, "R1", "valid after reset", out_valid, 1);
    check(out_bit == 1'b1, "R1", "first prefix bit", out_bit, 1);
    check(in_ready == 1'b0, "R1", "input blocked in prefix", in_ready, 0);
    check(out_last == 1'b0, "R8", "no last in prefix", out_last, 0);
    drain();
    compare("R1");
  endtask

  task automatic t_ones_codes();   // R2
    do_reset();
    send(1, 0); send(3, 0); send(17, 0); send(226, 1);
    drain();
    compare("R2");
  endtask

  task automatic t_capped();       // R3
    do_reset();
    send(227, 0); send(227, 0); send(2, 1);
    drain();
    compare("R3");
  endtask

  task automatic t_zero_runs();    // R4
    do_reset();
    send(228, 0); send(229, 0); send(240, 0); send(254, 1);
    drain();
    compare("R4");
  endtask

  task automatic t_single_one();   // R5
    do_reset();
    send(255, 0); send(5, 0); send(255, 1);
    drain();
    compare("R5");
  endtask

  task automatic t_null_code();    // R6
    do_reset();
    drain();
    compare("R1");
    add_code(0, 0);
    push_code(0, 0);
    #1;
    check(in_ready == 1'b1, "R6", "ready after code 0", in_ready, 1);
    check(out_valid == 1'b0, "R6", "no bit from code 0", out_valid, 0);
    send(2, 0);
    add_code(0, 1);
    push_code(0, 1);
    #1;
    check(out_valid == 1'b1 && in_ready == 1'b0, "R8", "prefix after last code 0",
          {out_valid, in_ready}, 2);
    drain();
    compare("R6");
  endtask

  task automatic t_last_flag();    // R8
    int lasts = 0;
    do_reset();
    send(4, 0); send(230, 1); send(227, 1);
    drain();
    foreach (got_q[i]) if (got_q[i][1]) lasts++;
    check(lasts == 2, "R8", "last flag count", lasts, 2);
    compare("R8");
  endtask

  task automatic t_backpressure(); // R9, R7
    do_reset();
    bp_en = 1'b1;
    stall_cnt = 0; stall_err = 0; ovl_err = 0;
    send(9, 0); send(227, 0); send(250, 0); send(255, 0); send(0, 0); send(1, 1); send(233, 1);
    drain();
    bp_en = 1'b0;
    compare("R9");
    check(stall_cnt > 0, "R9", "stalls seen", stall_cnt, 1);
    check(stall_err == 0, "R9", "output changed under stall", stall_err, 0);
    check(ovl_err == 0, "R7", "ready while bit pending", ovl_err, 0);
  endtask

  initial begin
    out_ready = 1'b1;
    t_reset_state();
    t_ones_codes();
    t_capped();
    t_zero_runs();
    t_single_one();
    t_null_code();
    t_last_flag();
    t_backpressure();
    summary();
  end
endmodule